// File: doc/BRIEF.md
# Error Record Bank with Interrupt Routing

This block gathers error events from memories, interrupt-translation units and the register interface into a bank of numbered error records. Each record has a fixed severity class and holds a valid flag, an overflow flag and an error code. Events arrive as single-cycle pulses that carry a record number and, for the software record, a code. The memory-type records come in pairs: the odd member of each pair is correctable and the even member is uncorrectable.

Two summary signals come out of the bank. The fault level is high while any uncorrectable record is valid. The error level is high while any correctable record is valid. Software can also route each summary to an internal interrupt ID. When it does, the block emits a one-cycle pulse with that ID whenever the matching level rises. A write of an ID that the system cannot accept clears the routing register to zero, and zero disables internal delivery. Parameters choose whether the LPI records exist and how many ITS units there are. Zero ITS units removes every ITS record.

Top module: `errRecordBank`

## Requirements
- R1: Record addresses 0-4, 7, 8, 11-12 (when NUM_ITS>0) and 13..12+NUM_ITS are present. Each present record reads with its class in bits 29:28. The class codes are 0 = correctable, 1 = recoverable, 2 = restartable/contained. Record 0 is class 2. Records 1, 3, 7, 9 and 11 are class 0. Record 12 is class 2. Records 2, 4, 8, 10 and 13+ are class 1.
- R2: When an event hits a record other than 0, bits 7:0 take a fixed code: 7 for records 1-10, 6 for records 11-12 and 14 for records 13 and up.
- R3: An event pulse (evtValid with evtRec) sets bit 31 (valid) of a present record on the next clock. For record 0, bits 7:0 take evtCode.
- R4: An event that reaches a record whose valid bit is already set also sets bit 30 (overflow). The code then takes the newest value.
- R5: A write with bit 31 set clears valid, overflow and code of that record. A write with bit 31 clear has no effect. A clear and an event in the same cycle leave the record valid with overflow clear.
- R6: Records 5 and 6, records 9-10 when HAS_LPI=0, and addresses at or above the record count other than 0x20 and 0x21 all read as zero. Writes and events aimed at them change nothing.
- R7: A read or write to an address that holds no register logs into record 0 with code BAD_CODE. If an event for record 0 arrives in the same cycle, overflow is also set and the code is BAD_CODE.
- R8: Address 0x20 is the error routing ID and 0x21 is the fault routing ID, held in bits ID_W-1:0. Writing a value below 32 makes the register read 0.
- R9: Writing a value above MAX_ID, or outside OWN_LO..OWN_HI, makes the register read 0. A legal value reads back unchanged.
- R10: faultIntLevel is high while any valid record is not correctable. errIntLevel is high while any valid record is correctable.
- R11: errIntPulse (or faultIntPulse) is high for one cycle, in the first cycle its level is high, only if the routing ID is nonzero. errIntId and faultIntId show the routing IDs.
- R12: After reset, every record is invalid with code 0, both routing IDs are 0, and all levels and pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Register address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, combinational |
| evtValid | input | 1 | Error event pulse |
| evtRec | input | ADDR_W | Record number of the event |
| evtCode | input | 8 | Error code, used by record 0 |
| errIntLevel | output | 1 | Any correctable record valid |
| faultIntLevel | output | 1 | Any uncorrectable record valid |
| errIntPulse | output | 1 | Internal delivery pulse for the error summary |
| errIntId | output | ID_W | Error routing ID |
| faultIntPulse | output | 1 | Internal delivery pulse for the fault summary |
| faultIntId | output | ID_W | Fault routing ID |

## Verification
The bench builds the bank with HAS_LPI=0 and NUM_ITS=2. This makes records 9-10 absent while record 12 and two command records (13 and 14) are present, so both the missing-record path and the multi-unit record path are exercised. MAX_ID=900 and an owned window of 64..511 separate the below-32, above-maximum and not-owned rejections from one another. That window also includes a value whose low bits alias a legal ID.

// File: rtl/errRecPkg.sv
`timescale 1ns/1ps
package errRecPkg;

  typedef enum logic [1:0] {
    SEV_CE  = 2'd0,
    SEV_UER = 2'd1,
    SEV_UEO = 2'd2
  } sevT;

  typedef struct packed {
    logic       set;
    logic       dbl;
    logic       clr;
    logic [7:0] code;
  } recStrobeT;

  localparam int DATA_W          = 32;
  localparam int VALID_BIT       = 31;
  localparam int ROUTE_ERR_ADDR  = 32;
  localparam int ROUTE_FLT_ADDR  = 33;

  function automatic logic [63:0] presentMask(input bit hasLpi, input int numIts);
    logic [63:0] m;
    m = '0;
    m[0] = 1'b1;
    m[1] = 1'b1; m[2] = 1'b1;
    m[3] = 1'b1; m[4] = 1'b1;
    m[7] = 1'b1; m[8] = 1'b1;
    if (hasLpi) begin
      m[9] = 1'b1; m[10] = 1'b1;
    end
    if (numIts > 0) begin
      m[11] = 1'b1; m[12] = 1'b1;
    end
    for (int i = 0; i < numIts; i++) m[13 + i] = 1'b1;
    return m;
  endfunction

  function automatic sevT recSev(input int r);
    if (r == 0)      return SEV_UEO;
    else if (r >= 13) return SEV_UER;
    else if (r == 12) return SEV_UEO;
    else if (r % 2 == 1) return SEV_CE;
    else             return SEV_UER;
  endfunction

  function automatic logic [7:0] recCode(input int r);
    if (r >= 13)      return 8'd14;
    else if (r >= 11) return 8'd6;
    else              return 8'd7;
  endfunction

endpackage

// File: rtl/errRecCtrl.sv
`timescale 1ns/1ps
module errRecCtrl
  import errRecPkg::*;
#(
  parameter int HAS_LPI  = 1,
  parameter int NUM_ITS  = 1,
  parameter int ADDR_W   = 6,
  parameter int ID_W     = 10,
  parameter int MAX_ID   = 1019,
  parameter int OWN_LO   = 32,
  parameter int OWN_HI   = 1019,
  parameter logic [7:0] BAD_CODE = 8'h0F,
  localparam int NUM_REC = 13 + NUM_ITS
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              regWrEn,
  input  logic                              regRdEn,
  input  logic [ADDR_W-1:0]                 regAddr,
  input  logic [DATA_W-1:0]                 regWrData,
  input  logic                              evtValid,
  input  logic [ADDR_W-1:0]                 evtRec,
  input  logic [7:0]                        evtCode,
  input  logic [NUM_REC-1:0][DATA_W-1:0]    recStatus,
  input  logic                              errLevel,
  input  logic                              faultLevel,
  output recStrobeT [NUM_REC-1:0]           strobe,
  output logic [DATA_W-1:0]                 regRdData,
  output logic                              errPulse,
  output logic                              faultPulse,
  output logic [ID_W-1:0]                   errRoute,
  output logic [ID_W-1:0]                   faultRoute
);

  localparam logic [63:0] PRESENT = presentMask(HAS_LPI != 0, NUM_ITS);
  localparam logic [ADDR_W-1:0] ERR_A = ADDR_W'(ROUTE_ERR_ADDR);
  localparam logic [ADDR_W-1:0] FLT_A = ADDR_W'(ROUTE_FLT_ADDR);

  logic mapped, badAccess, errLevelQ, faultLevelQ;

  function automatic logic idLegal(input logic [DATA_W-1:0] d);
    return (d >= 32'd32) && (d <= 32'(MAX_ID)) &&
           (d >= 32'(OWN_LO)) && (d <= 32'(OWN_HI));
  endfunction

  assign mapped    = PRESENT[6'(regAddr)] || (regAddr == ERR_A) || (regAddr == FLT_A);
  assign badAccess = (regRdEn || regWrEn) && !mapped;

  always_comb begin
    for (int r = 0; r < NUM_REC; r++) begin
      logic hit;
      hit = evtValid && (evtRec == ADDR_W'(r));
      strobe[r].set  = PRESENT[r] && (hit || (r == 0 && badAccess));
      strobe[r].dbl  = (r == 0) && hit && badAccess;
      strobe[r].clr  = PRESENT[r] && regWrEn && (regAddr == ADDR_W'(r)) &&
                       regWrData[VALID_BIT];
      if (r == 0) strobe[r].code = badAccess ? BAD_CODE : evtCode;
      else        strobe[r].code = recCode(r);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errRoute    <= '0;
      faultRoute  <= '0;
      errLevelQ   <= 1'b0;
      faultLevelQ <= 1'b0;
    end else begin
      errLevelQ   <= errLevel;
      faultLevelQ <= faultLevel;
      if (regWrEn && regAddr == ERR_A)
        errRoute <= idLegal(regWrData) ? regWrData[ID_W-1:0] : '0;
      if (regWrEn && regAddr == FLT_A)
        faultRoute <= idLegal(regWrData) ? regWrData[ID_W-1:0] : '0;
    end
  end

  assign errPulse   = errLevel && !errLevelQ && (errRoute != '0);
  assign faultPulse = faultLevel && !faultLevelQ && (faultRoute != '0);

  always_comb begin
    regRdData = '0;
    if (regAddr == ERR_A)      regRdData = DATA_W'(errRoute);
    else if (regAddr == FLT_A) regRdData = DATA_W'(faultRoute);
    else begin
      for (int r = 0; r < NUM_REC; r++)
        if (regAddr == ADDR_W'(r)) regRdData = recStatus[r];
    end
  end

endmodule

// File: rtl/errRecData.sv
`timescale 1ns/1ps
module errRecData
  import errRecPkg::*;
#(
  parameter int HAS_LPI  = 1,
  parameter int NUM_ITS  = 1,
  localparam int NUM_REC = 13 + NUM_ITS
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  recStrobeT [NUM_REC-1:0]        strobe,
  output logic [NUM_REC-1:0][DATA_W-1:0] recStatus,
  output logic                           errLevel,
  output logic                           faultLevel
);

  localparam logic [63:0] PRESENT = presentMask(HAS_LPI != 0, NUM_ITS);

  logic [NUM_REC-1:0] errVec, faultVec;

  for (genvar r = 0; r < NUM_REC; r++) begin : g_rec
    if (PRESENT[r]) begin : g_on
      localparam sevT SEV = recSev(r);
      logic       valid, ovf;
      logic [7:0] code;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          valid <= 1'b0;
          ovf   <= 1'b0;
          code  <= '0;
        end else if (strobe[r].set) begin
          valid <= 1'b1;
          ovf   <= (valid && !strobe[r].clr) || strobe[r].dbl;
          code  <= strobe[r].code;
        end else if (strobe[r].clr) begin
          valid <= 1'b0;
          ovf   <= 1'b0;
          code  <= '0;
        end
      end

      assign recStatus[r] = {valid, ovf, SEV, 20'b0, code};
      assign errVec[r]    = valid && (SEV == SEV_CE);
      assign faultVec[r]  = valid && (SEV != SEV_CE);
    end else begin : g_off
      assign recStatus[r] = '0;
      assign errVec[r]    = 1'b0;
      assign faultVec[r]  = 1'b0;
    end
  end

  assign errLevel   = |errVec;
  assign faultLevel = |faultVec;

endmodule

// File: rtl/errRecordBank.sv
`timescale 1ns/1ps
module errRecordBank
  import errRecPkg::*;
#(
  parameter int HAS_LPI  = 1,
  parameter int NUM_ITS  = 1,
  parameter int ADDR_W   = 6,
  parameter int ID_W     = 10,
  parameter int MAX_ID   = 1019,
  parameter int OWN_LO   = 32,
  parameter int OWN_HI   = 1019,
  parameter logic [7:0] BAD_CODE = 8'h0F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              evtValid,
  input  logic [ADDR_W-1:0] evtRec,
  input  logic [7:0]        evtCode,
  output logic              errIntLevel,
  output logic              faultIntLevel,
  output logic              errIntPulse,
  output logic [ID_W-1:0]   errIntId,
  output logic              faultIntPulse,
  output logic [ID_W-1:0]   faultIntId
);

  localparam int NUM_REC = 13 + NUM_ITS;

  recStrobeT [NUM_REC-1:0]        strobe;
  logic [NUM_REC-1:0][DATA_W-1:0] recStatus;

  errRecCtrl #(
    .HAS_LPI(HAS_LPI), .NUM_ITS(NUM_ITS), .ADDR_W(ADDR_W), .ID_W(ID_W),
    .MAX_ID(MAX_ID), .OWN_LO(OWN_LO), .OWN_HI(OWN_HI), .BAD_CODE(BAD_CODE)
  ) i_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .evtValid(evtValid), .evtRec(evtRec), .evtCode(evtCode),
    .recStatus(recStatus), .errLevel(errIntLevel), .faultLevel(faultIntLevel),
    .strobe(strobe), .regRdData(regRdData),
    .errPulse(errIntPulse), .faultPulse(faultIntPulse),
    .errRoute(errIntId), .faultRoute(faultIntId)
  );

  errRecData #(
    .HAS_LPI(HAS_LPI), .NUM_ITS(NUM_ITS)
  ) i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .recStatus(recStatus),
    .errLevel(errIntLevel), .faultLevel(faultIntLevel)
  );

endmodule

// File: rtl/errRecChk.sv
`timescale 1ns/1ps
module errRecChk #(
  parameter int ADDR_W = 6,
  parameter int ID_W   = 10,
  parameter int MAX_ID = 1019
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       regWrData,
  input logic [31:0]       regRdData,
  input logic              evtValid,
  input logic              errIntLevel,
  input logic              faultIntLevel,
  input logic              errIntPulse,
  input logic [ID_W-1:0]   errIntId,
  input logic              faultIntPulse,
  input logic [ID_W-1:0]   faultIntId
);

  // R8: a routing ID below 32 reads back as zero
  a_r8_low_id_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(32) && regWrData < 32'd32) |=> (errIntId == '0));

  // R9: a routing ID above the maximum reads back as zero
  a_r9_high_id_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(33) && regWrData > 32'(MAX_ID)) |=> (faultIntId == '0));

  // R11: internal delivery needs a raised level and a nonzero route
  a_r11_pulse_needs_route: assert property (@(posedge clk) disable iff (!rstN)
    errIntPulse |-> (errIntLevel && errIntId != '0));

  // R11: delivery pulse lasts one cycle
  a_r11_fault_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    faultIntPulse |=> !faultIntPulse);

  // R6: reserved records read zero
  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(5) || regAddr == ADDR_W'(6)) |-> (regRdData == '0));

  // R10: the fault level rises only after an event or a register access
  a_r10_fault_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultIntLevel) |-> $past(evtValid || regRdEn || regWrEn));

endmodule

bind errRecordBank errRecChk #(.ADDR_W(ADDR_W), .ID_W(ID_W), .MAX_ID(MAX_ID)) i_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
  .regWrData(regWrData), .regRdData(regRdData), .evtValid(evtValid),
  .errIntLevel(errIntLevel), .faultIntLevel(faultIntLevel),
  .errIntPulse(errIntPulse), .errIntId(errIntId),
  .faultIntPulse(faultIntPulse), .faultIntId(faultIntId)
);

// File: tb/test_errRecordBank.sv
`timescale 1ns/1ps
module test_errRecordBank;

  localparam int HAS_LPI = 0;
  localparam int NUM_ITS = 2;
  localparam int ADDR_W  = 6;
  localparam int ID_W    = 10;
  localparam int MAX_ID  = 900;
  localparam int OWN_LO  = 64;
  localparam int OWN_HI  = 511;
  localparam logic [7:0] BAD = 8'h0F;
  localparam int NREC    = 13 + NUM_ITS;

  logic clk = 0, rstN = 0;
  logic regWrEn = 0, regRdEn = 0, evtValid = 0;
  logic [ADDR_W-1:0] regAddr = '0, evtRec = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic [7:0] evtCode = '0;
  logic errIntLevel, faultIntLevel, errIntPulse, faultIntPulse;
  logic [ID_W-1:0] errIntId, faultIntId;

  always #2.5 clk = ~clk;

  errRecordBank #(
    .HAS_LPI(HAS_LPI), .NUM_ITS(NUM_ITS), .ADDR_W(ADDR_W), .ID_W(ID_W),
    .MAX_ID(MAX_ID), .OWN_LO(OWN_LO), .OWN_HI(OWN_HI), .BAD_CODE(BAD)
  ) i_errRecordBank (.*);

  int nChecks = 0, nErrors = 0;
  bit done = 0;

  // reference state
  bit       mV [NREC];
  bit       mO [NREC];
  int       mC [NREC];
  int       mErrId = 0, mFltId = 0;
  bit       prevErr = 0, prevFlt = 0;

  function automatic bit isPresent(int r);
    if (r < 0 || r >= NREC) return 0;
    if (r == 5 || r == 6) return 0;
    if ((r == 9 || r == 10) && HAS_LPI == 0) return 0;
    if (r >= 11 && NUM_ITS == 0) return 0;
    return 1;
  endfunction

  function automatic int clsOf(int r);
    if (r == 0 || r == 12) return 2;
    if (r >= 13) return 1;
    return (r % 2 == 1) ? 0 : 1;
  endfunction

  function automatic int fixedCode(int r);
    if (r >= 13) return 14;
    if (r >= 11) return 6;
    return 7;
  endfunction

  function automatic bit legalId(logic [31:0] d);
    return d >= 32 && d <= MAX_ID && d >= OWN_LO && d <= OWN_HI;
  endfunction

  function automatic logic [31:0] expRead(int a);
    if (a == 32) return 32'(mErrId);
    if (a == 33) return 32'(mFltId);
    if (!isPresent(a)) return 0;
    return {mV[a], mO[a], 2'(clsOf(a)), 20'b0, 8'(mC[a])};
  endfunction

  function automatic bit expErrLvl();
    for (int r = 0; r < NREC; r++) if (isPresent(r) && mV[r] && clsOf(r) == 0) return 1;
    return 0;
  endfunction

  function automatic bit expFltLvl();
    for (int r = 0; r < NREC; r++) if (isPresent(r) && mV[r] && clsOf(r) != 0) return 1;
    return 0;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit rd, bit wr, int addr, logic [31:0] wd,
                      bit ev, int rec, logic [7:0] code);
    bit bad, eL, fL;
    regRdEn = rd; regWrEn = wr; regAddr = ADDR_W'(addr); regWrData = wd;
    evtValid = ev; evtRec = ADDR_W'(rec); evtCode = code;
    #1;
    eL = expErrLvl(); fL = expFltLvl();
    chk(tag, "regRdData", regRdData, expRead(addr));
    chk(tag, "errIntLevel", 32'(errIntLevel), 32'(eL));
    chk(tag, "faultIntLevel", 32'(faultIntLevel), 32'(fL));
    chk(tag, "errIntPulse", 32'(errIntPulse), 32'(eL && !prevErr && mErrId != 0));
    chk(tag, "faultIntPulse", 32'(faultIntPulse), 32'(fL && !prevFlt && mFltId != 0));
    chk(tag, "errIntId", 32'(errIntId), 32'(mErrId));
    chk(tag, "faultIntId", 32'(faultIntId), 32'(mFltId));
    bad = (rd || wr) && !(isPresent(addr) || addr == 32 || addr == 33);
    @(posedge clk);
    prevErr = eL; prevFlt = fL;
    for (int r = 0; r < NREC; r++) begin
      bit hit, setIt;
      if (!isPresent(r)) continue;
      hit = ev && rec == r;
      setIt = hit || (r == 0 && bad);
      if (wr && addr == r && wd[31]) begin mV[r] = 0; mO[r] = 0; mC[r] = 0; end
      if (setIt) begin
        if (mV[r] || (r == 0 && hit && bad)) mO[r] = 1;
        mV[r] = 1;
        mC[r] = (r == 0) ? (bad ? int'(BAD) : int'(code)) : fixedCode(r);
      end
    end
    if (wr && addr == 32) mErrId = legalId(wd) ? int'(wd[ID_W-1:0]) : 0;
    if (wr && addr == 33) mFltId = legalId(wd) ? int'(wd[ID_W-1:0]) : 0;
    @(negedge clk);
  endtask

  task automatic rdA(string tag, int a);  step(tag, 1, 0, a, 0, 0, 0, 0); endtask
  task automatic wrA(string tag, int a, logic [31:0] d); step(tag, 0, 1, a, d, 0, 0, 0); endtask
  task automatic evA(string tag, int rec, logic [7:0] c); step(tag, 0, 0, 0, 0, 1, rec, c); endtask

  initial begin
    for (int r = 0; r < NREC; r++) begin mV[r] = 0; mO[r] = 0; mC[r] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    // R12: reset state
    rdA("R12", 32); rdA("R12", 33); rdA("R12", 0);
    // R1: class field of every present record
    for (int a = 0; a < NREC; a++) if (isPresent(a)) rdA("R1", a);
    // R8: low IDs rejected
    wrA("R8", 32, 20); rdA("R8", 32);
    wrA("R8", 33, 31); rdA("R8", 33);
    // R9: out of range, not owned, aliasing and legal IDs
    wrA("R9", 32, 950); rdA("R9", 32);
    wrA("R9", 32, 40);  rdA("R9", 32);
    wrA("R9", 32, 32'h0001_0064); rdA("R9", 32);
    wrA("R9", 32, 100); rdA("R9", 32);
    wrA("R9", 33, 300); rdA("R9", 33);
    // R3 / R10 / R11: correctable event raises error level and pulse
    evA("R3", 1, 8'h00); rdA("R3", 1);
    evA("R11", 3, 8'h00); step("R11", 0, 0, 0, 0, 0, 0, 0);
    // R2 / R10: uncorrectable events and fault pulse
    evA("R10", 2, 8'h00); rdA("R2", 2);
    evA("R2", 13, 8'h00); rdA("R2", 13);
    evA("R2", 14, 8'h00); rdA("R2", 14);
    evA("R2", 11, 8'h00); rdA("R2", 11);
    evA("R2", 12, 8'h00); rdA("R2", 12);
    evA("R2", 8, 8'h00);  rdA("R2", 8);
    // R3: software record takes event code
    evA("R3", 0, 8'h33); rdA("R3", 0);
    // R4: second event sets overflow
    evA("R4", 1, 8'h00); rdA("R4", 1);
    evA("R4", 0, 8'h55); rdA("R4", 0);
    // R5: clearing
    wrA("R5", 1, 32'h7FFF_FFFF); rdA("R5", 1);
    wrA("R5", 1, 32'h8000_0000); rdA("R5", 1);
    step("R5", 0, 1, 3, 32'h8000_0000, 1, 3, 8'h00); rdA("R5", 3);
    wrA("R5", 3, 32'h8000_0000); wrA("R5", 11, 32'h8000_0000); rdA("R10", 3);
    evA("R11", 7, 8'h00); rdA("R11", 7);
    // R6 / R7: reserved, absent and unmapped addresses
    wrA("R7", 0, 32'h8000_0000); rdA("R7", 0);
    rdA("R6", 5); rdA("R7", 0);
    wrA("R6", 0, 32'h8000_0000);
    rdA("R6", 6); rdA("R6", 9); rdA("R6", 10); rdA("R6", 20);
    wrA("R6", 9, 32'h8000_0000); wrA("R6", 5, 32'hFFFF_FFFF);
    evA("R6", 5, 8'h11); evA("R6", 9, 8'h11); evA("R6", 10, 8'h11);
    evA("R6", 15, 8'h11); evA("R6", 40, 8'h11);
    rdA("R6", 9); rdA("R6", 5);
    wrA("R7", 0, 32'h8000_0000);
    wrA("R7", 48, 32'h1234_5678); rdA("R7", 0);
    wrA("R7", 0, 32'h8000_0000);
    step("R7", 0, 1, 48, 0, 1, 0, 8'h44); rdA("R7", 0);
    // R11: zero route suppresses fault pulse
    wrA("R11", 33, 10);
    for (int r = 0; r < NREC; r++) if (isPresent(r)) wrA("R11", r, 32'h8000_0000);
    evA("R11", 12, 8'h00); rdA("R11", 12);
    evA("R11", 9, 8'h00); rdA("R11", 33);
    // R12: reset again clears everything
    rstN = 0; #1;
    for (int r = 0; r < NREC; r++) begin mV[r] = 0; mO[r] = 0; mC[r] = 0; end
    mErrId = 0; mFltId = 0; prevErr = 0; prevFlt = 0;
    @(negedge clk); rstN = 1;
    rdA("R12", 12); rdA("R12", 32); rdA("R12", 33);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      nChecks++; nErrors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

endmodule